// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a stream of asynchronous serial characters on one data line into parallel words. It runs entirely on a local receive clock that ticks four times per bit period. The line rests high. A high-to-low transition announces a character. The bit period and the number of data bits are fixed in advance on both ends of the link. The receiver does not recover a clock from the line. It counts its own clock from the start transition and reads the line once per bit, as close to the middle of the bit as four ticks allow.

The raw line first passes through a two-stage synchronizer. An edge detector then watches the synchronized level. A 2-bit phase counter starts at the detected edge. Each time the counter's top bit rises, a sample strobe fires, and the strobes come four clocks apart. The first strobe checks that the line is still low; if it is high, the character is dropped as noise. Each later strobe shifts one data bit into a shift register, least significant bit first. After the last data bit, the word appears on the output with a one-cycle valid pulse, and the receiver goes back to watching for the next start edge.

Top module: `serial_rx_os4`

## Requirements
- R1: While the synchronized line stays high, or holds a level without a high-to-low transition, no reception begins and `valid_o` stays 0.
- R2: The input passes through a two-flop synchronizer. For a start transition that `rx_i` makes between two clock edges, `valid_o` is high in the cycle that begins 4*DATA_BITS+5 rising edges later (37 for 8 data bits).
- R3: Within each 4-clock bit interval (positions 0..3, counted from the synchronized start edge), only the value at position 2 is used. The line level at positions 0, 1 and 3 of each data bit has no effect on the received word.
- R4: Data bits arrive least significant bit first. The first data bit after the start bit becomes `data_o[0]` and the last becomes `data_o[DATA_BITS-1]`.
- R5: `valid_o` is high for exactly one cycle per accepted character. `data_o` changes only in the cycle where `valid_o` rises, and holds its value until the next accepted character.
- R6: If the line reads 1 at the centre sample of the start bit (a low pulse of one or two clocks), the character is abandoned. No valid pulse follows, and the receiver waits for a new start edge.
- R7: After the last data bit is sampled, the receiver accepts a new start edge at once, so frames with a one-bit stop interval are all received.
- R8: While `rst_ni` is low, `valid_o` and `data_o` are 0 and any partial character is discarded. After release, the line is treated as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock, four ticks per bit period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | DATA_BITS | Last received word, LSB received first |
| valid_o | output | 1 | One-cycle strobe marking a new word on data_o |

## Verification
The bench drives each bit value for a whole bit period. The correct sample position is checked with frames in which every data bit shows its true value only at position 2 and the inverse elsewhere. A receiver sampling one clock early or late then returns the complementary pattern. The exact cycle of the valid pulse is measured from the start edge, which exposes a missing synchronizer stage or an off-by-one in the phase counter or bit counter. Low pulses of one and two clocks must produce no word and leave data_o unchanged, which catches a receiver that skips the start-bit check. Back-to-back frames and a reset in mid-character catch a receiver that stays busy too long or keeps stale state.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // reset to 1 so the line reads idle after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_phase.sv
module rx_phase #(
  parameter int OVERSAMPLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic strobe_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CENTRE = CNT_W'(OVERSAMPLE/2 - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  // fires on the edge where the counter MSB rises
  assign strobe_o = run_i && (cnt_q == CENTRE);

  p_strobe_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  p_strobe_gap2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ##2 !strobe_o);
  p_clear_defers_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !strobe_o);
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {bit_i, word_o[WIDTH-1:1]};
  end

  p_shift_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(word_o));
endmodule

// File: rtl/serial_rx_os4.sv
module serial_rx_os4
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  localparam int OVERSAMPLE = 4;
  localparam int BCNT_W     = $clog2(DATA_BITS + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_BITS);

  rx_state_e         state_q;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic              line, line_prev_q, fall;
  logic              strobe, running, shift_en, last_bit;
  logic [DATA_BITS-1:0] word;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_prev_q <= 1'b1;
    else         line_prev_q <= line;
  end

  assign fall    = line_prev_q && !line;
  assign running = (state_q == RX_RUN);

  rx_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!running),
    .run_i   (running),
    .strobe_o(strobe)
  );

  assign shift_en = strobe && (bit_cnt_q != '0);
  assign last_bit = strobe && (bit_cnt_q == LAST_BIT);

  rx_shift #(.WIDTH(DATA_BITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (line),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      bit_cnt_q <= '0;
      valid_o   <= 1'b0;
      data_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          bit_cnt_q <= '0;
          if (fall) state_q <= RX_RUN;
        end
        RX_RUN: begin
          if (strobe) begin
            if (bit_cnt_q == '0) begin
              // start-bit centre: high means noise
              if (line) state_q <= RX_IDLE;
              else      bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (last_bit) begin
              state_q   <= RX_IDLE;
              bit_cnt_q <= '0;
              valid_o   <= 1'b1;
              data_o    <= {line, word[DATA_BITS-1:1]};
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  p_idle_wait_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && !fall) |=> state_q == RX_IDLE);
  p_valid_from_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(state_q == RX_RUN));
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
  p_false_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && strobe && bit_cnt_q == '0 && line) |=> (state_q == RX_IDLE && !valid_o));
  p_ready_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> state_q == RX_IDLE);
endmodule

// File: tb/sim_serial_rx_os4.sv
module sim_serial_rx_os4;
  localparam int NB  = 8;
  localparam int LAT = 4 * NB + 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_i = 1'b1;
  logic [NB-1:0] data_o;
  logic          valid_o;

  serial_rx_os4 #(.DATA_BITS(NB)) u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .data_o(data_o),
    .valid_o(valid_o)
  );

  always #2 clk_i = ~clk_i;

  int total = 0;
  int fails = 0;
  int tick = 0;
  int vcount = 0;
  int last_tick = 0;
  int width_err = 0;
  bit prev_valid = 1'b0;
  bit done = 1'b0;
  logic [NB-1:0] got [16];

  // {sent byte, expected word}
  localparam logic [15:0] VEC [6] = '{
    16'hA5A5, 16'h0000, 16'hFFFF, 16'h0101, 16'h8080, 16'h3C3C
  };

  always @(posedge clk_i) tick <= tick + 1;

  always @(negedge clk_i) begin
    if (valid_o) begin
      got[vcount[3:0]] = data_o;
      vcount = vcount + 1;
      last_tick = tick;
      if (prev_valid) width_err = width_err + 1;
    end
    prev_valid = valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [NB-1:0] b, output int st);
    @(negedge clk_i);
    st = tick;
    hold(1'b0, 4);
    for (int i = 0; i < NB; i++) hold(b[i], 4);
    hold(1'b1, 4);
  endtask

  // true bit value only at position 2, inverse elsewhere
  task automatic send_centre(input logic [NB-1:0] b);
    @(negedge clk_i);
    hold(1'b0, 4);
    for (int i = 0; i < NB; i++) begin
      hold(~b[i], 2);
      hold(b[i], 1);
      hold(~b[i], 1);
    end
    hold(1'b1, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int st, vc0;
    logic [NB-1:0] held;

    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 valid in reset", valid_o, 0);
    chk(data_o == '0, "R8 data in reset", data_o, 0);
    rst_ni = 1'b1;

    // R1 idle line produces nothing
    repeat (30) @(negedge clk_i);
    chk(vcount == 0, "R1 idle no valid", vcount, 0);

    // table of frames: R2 latency, R4 bit order, R5 single pulse
    for (int k = 0; k < 6; k++) begin
      vc0 = vcount;
      send_frame(VEC[k][15:8], st);
      repeat (4) @(negedge clk_i);
      chk(vcount == vc0 + 1, "R5 one word per frame", vcount - vc0, 1);
      chk(got[vc0[3:0]] == VEC[k][7:0], "R4 word value", got[vc0[3:0]], VEC[k][7:0]);
      chk(last_tick - st == LAT, "R2 valid latency", last_tick - st, LAT);
    end
    chk(width_err == 0, "R5 valid width", width_err, 0);

    // R6 one-clock and two-clock low pulses
    held = data_o;
    vc0 = vcount;
    @(negedge clk_i);
    hold(1'b0, 1);
    hold(1'b1, 60);
    chk(vcount == vc0, "R6 1-clock glitch ignored", vcount - vc0, 0);
    chk(data_o == held, "R5 data held after glitch", data_o, held);
    hold(1'b0, 2);
    hold(1'b1, 60);
    chk(vcount == vc0, "R6 2-clock glitch ignored", vcount - vc0, 0);
    chk(data_o == held, "R5 data held after glitch2", data_o, held);
    send_frame(8'h69, st);
    repeat (4) @(negedge clk_i);
    chk(vcount == vc0 + 1 && data_o == 8'h69, "R6 recovers after glitch", data_o, 8'h69);

    // R3 centre sampling
    vc0 = vcount;
    send_centre(8'h5A);
    repeat (4) @(negedge clk_i);
    chk(vcount == vc0 + 1, "R3 centre frame count", vcount - vc0, 1);
    chk(data_o == 8'h5A, "R3 centre sample value", data_o, 8'h5A);
    vc0 = vcount;
    send_centre(8'hC1);
    repeat (4) @(negedge clk_i);
    chk(data_o == 8'hC1, "R3 centre sample value 2", data_o, 8'hC1);

    // R7 back-to-back frames
    vc0 = vcount;
    send_frame(8'h12, st);
    send_frame(8'hEE, st);
    send_frame(8'h00, st);
    repeat (4) @(negedge clk_i);
    chk(vcount == vc0 + 3, "R7 back-to-back count", vcount - vc0, 3);
    chk(got[vc0[3:0]] == 8'h12, "R7 first word", got[vc0[3:0]], 8'h12);
    chk(got[4'(vc0 + 1)] == 8'hEE, "R7 second word", got[4'(vc0 + 1)], 8'hEE);
    chk(got[4'(vc0 + 2)] == 8'h00, "R7 third word", got[4'(vc0 + 2)], 8'h00);

    // R8 reset mid-character
    vc0 = vcount;
    @(negedge clk_i);
    hold(1'b0, 4);
    for (int i = 0; i < 5; i++) hold(i[0], 4);
    rst_ni = 1'b0;
    rx_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(data_o == '0 && valid_o == 1'b0, "R8 mid-frame reset clears", data_o, 0);
    rst_ni = 1'b1;
    repeat (50) @(negedge clk_i);
    chk(vcount == vc0, "R8 partial frame dropped", vcount - vc0, 0);
    send_frame(8'hC3, st);
    repeat (4) @(negedge clk_i);
    chk(vcount == vc0 + 1 && data_o == 8'hC3, "R8 frame after reset", data_o, 8'hC3);
    chk(width_err == 0, "R5 valid width final", width_err, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule